// File: doc/BRIEF.md
# Presence-Flag Coherence Directory Controller

This block sits beside main memory in a small cache-coherent multiprocessor and keeps one directory entry per tracked memory block. Each entry holds a dirty flag and one presence flag per cache. Caches send read misses and write misses to the controller. The controller answers each miss with a shared or exclusive grant that carries the block data. When coherence requires it, the controller first sends invalidations to the current sharers, or a recall to the cache holding a modified copy. It then collects the acknowledgments or the returned data before it replies.

Only one transaction is in flight at a time, and it locks its block. A request for the locked block is answered at once with a retry, and the cache reissues it later. A request for any other block waits at the request handshake until the controller is idle again. A cache that evicts a modified block sends its data back unprompted. Memory takes that data and the directory drops the cache.

Top module: `coh_dir_ctrl`

## Requirements
- R1: After reset no response or probe is valid, `req_ready` is high, every directory entry is clean with no sharers, and memory block i holds the value i.
- R2: A read miss to a clean block gets a shared grant (`rsp_kind` 0) carrying the memory value. The grant is valid in the cycle right after the request is accepted, and the requester's presence flag is set.
- R3: A write miss to a clean block with no sharers other than the requester gets an exclusive grant (`rsp_kind` 1) in the cycle after acceptance. The entry becomes dirty with only the writer present.
- R4: A write miss to a clean block with other sharers sends one invalidate probe (`prb_kind` 0) to each sharer except the requester, in ascending cache index, and to no other cache. The exclusive grant is withheld until every one of those caches has acknowledged (`cin_wb` 0).
- R5: A miss to a block dirty in another cache sends exactly one recall probe (`prb_kind` 1) to that owner. Memory takes the owner's write-back (`cin_wb` 1), and the grant then carries the written-back value.
- R6: After a read miss served through a recall, the entry is clean with both the former owner and the reader present.
- R7: After any write miss completes, the entry is dirty with only the writer present, so a later miss by another cache recalls from that writer.
- R8: While a transaction is in flight, a request for its block is accepted and answered in the next cycle with a retry (`rsp_kind` 2) addressed to the requester. The block and its entry are left unchanged.
- R9: While a transaction is in flight, a request for any other block is held off with `req_ready` low.
- R10: An unsolicited write-back from the owner of a dirty block updates memory and clears the dirty flag and that cache's presence flag. A write-back from a cache that does not own a dirty copy changes nothing.
- R11: An acknowledgment from a cache that was not sent an invalidate, or one naming a different block, does not count toward releasing the grant.
- R12: A miss from the cache that already owns the dirty block is answered at once with an exclusive grant, and the entry is left unchanged.
- R13: A valid response or probe holds all of its fields stable until its ready input is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Miss request valid |
| req_ready | output | 1 | Miss request accepted this cycle |
| req_src | input | CW | Requesting cache index |
| req_line | input | LW | Block index of the miss |
| req_wr | input | 1 | 1 = write miss, 0 = read miss |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_dst | output | CW | Destination cache of the response |
| rsp_kind | output | 2 | 0 shared grant, 1 exclusive grant, 2 retry |
| rsp_line | output | LW | Block index of the response |
| rsp_data | output | DW | Block data (zero on retry) |
| prb_valid | output | 1 | Probe valid |
| prb_ready | input | 1 | Probe taken |
| prb_dst | output | CW | Probed cache |
| prb_kind | output | 1 | 0 invalidate, 1 recall |
| prb_line | output | LW | Probed block |
| cin_valid | input | 1 | Cache-to-directory message valid (always taken) |
| cin_src | input | CW | Sending cache |
| cin_wb | input | 1 | 1 write-back with data, 0 invalidate acknowledgment |
| cin_line | input | LW | Block index of the message |
| cin_data | input | DW | Write-back data |

## Verification
Misses are tried against clean blocks with zero, one and several sharers, against blocks dirty in another cache, and against blocks dirty in the requester itself. Together these separate the immediate grant, the invalidate fan-out and the recall path. Invalidations are answered after a stray acknowledgment from the requester and a misaddressed acknowledgment from a real sharer, so a counter that accepts either one releases the grant too early. A held recall allows a same-block request, which must be bounced, and a different-block request, which must stall, to be tried while the line is locked. Random evictions, some from non-owners, are mixed with random misses over a few blocks, so later grants show whether memory and the sharer flags were kept right.

// File: rtl/coh_dir_ctrl.sv
module coh_dir_ctrl #(
  parameter int NCACHE = 4,
  parameter int NLINES = 16,
  parameter int DW = 32,
  localparam int CW = (NCACHE > 1) ? $clog2(NCACHE) : 1,
  localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1,
  localparam int AW = $clog2(NCACHE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [CW-1:0] req_src,
  input  logic [LW-1:0] req_line,
  input  logic          req_wr,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [CW-1:0] rsp_dst,
  output logic [1:0]    rsp_kind,
  output logic [LW-1:0] rsp_line,
  output logic [DW-1:0] rsp_data,
  output logic          prb_valid,
  input  logic          prb_ready,
  output logic [CW-1:0] prb_dst,
  output logic          prb_kind,
  output logic [LW-1:0] prb_line,
  input  logic          cin_valid,
  input  logic [CW-1:0] cin_src,
  input  logic          cin_wb,
  input  logic [LW-1:0] cin_line,
  input  logic [DW-1:0] cin_data
);

  typedef enum logic [2:0] {S_IDLE, S_INV, S_ACK, S_RCL, S_WB, S_RPL} st_t;
  localparam logic [1:0] K_SHR = 2'd0, K_EXC = 2'd1, K_RTY = 2'd2;

  st_t                          st_q;
  logic [CW-1:0]                src_q, own_q;
  logic [LW-1:0]                line_q;
  logic                         wr_q;
  logic [NCACHE-1:0]            snd_q, wait_q;
  logic [AW-1:0]                cnt_q;
  logic [NLINES-1:0]            lock_q, dirty_q;
  logic [NLINES-1:0][NCACHE-1:0] pres_q;
  logic [NLINES-1:0][DW-1:0]    mem_q;

  function automatic logic [CW-1:0] low_idx(input logic [NCACHE-1:0] v);
    low_idx = '0;
    for (int i = NCACHE - 1; i >= 0; i--)
      if (v[i]) low_idx = CW'(i);
  endfunction

  function automatic logic [AW-1:0] pop(input logic [NCACHE-1:0] v);
    pop = '0;
    for (int i = 0; i < NCACHE; i++)
      pop = pop + AW'(v[i]);
  endfunction

  logic              idle, req_fire, prb_fire;
  logic              req_dirty, own_self, ack_hit, wb_rcl, wb_evict;
  logic [NCACHE-1:0] req_bit, req_ent, req_oth, cin_bit, prb_bit, src_bit, own_bit;

  assign idle      = (st_q == S_IDLE);
  assign req_bit   = NCACHE'(1) << req_src;
  assign req_ent   = pres_q[req_line];
  assign req_dirty = dirty_q[req_line];
  assign own_self  = req_dirty && |(req_ent & req_bit);
  assign req_oth   = req_ent & ~req_bit;
  assign req_ready = idle ? (!rsp_valid && !(cin_valid && cin_wb))
                          : (st_q != S_RPL && lock_q[req_line] && !rsp_valid);
  assign req_fire  = req_valid && req_ready;

  assign prb_valid = (st_q == S_INV) || (st_q == S_RCL);
  assign prb_kind  = (st_q == S_RCL);
  assign prb_dst   = (st_q == S_RCL) ? own_q : low_idx(snd_q);
  assign prb_line  = line_q;
  assign prb_fire  = prb_valid && prb_ready;
  assign prb_bit   = NCACHE'(1) << prb_dst;

  assign cin_bit   = NCACHE'(1) << cin_src;
  assign src_bit   = NCACHE'(1) << src_q;
  assign own_bit   = NCACHE'(1) << own_q;
  assign ack_hit   = cin_valid && !cin_wb && (st_q == S_INV || st_q == S_ACK)
                     && cin_line == line_q && |(wait_q & cin_bit);
  assign wb_rcl    = cin_valid && cin_wb && (st_q == S_RCL || st_q == S_WB)
                     && cin_src == own_q && cin_line == line_q;
  assign wb_evict  = cin_valid && cin_wb && !wb_rcl && dirty_q[cin_line]
                     && |(pres_q[cin_line] & cin_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      src_q     <= '0;
      own_q     <= '0;
      line_q    <= '0;
      wr_q      <= 1'b0;
      snd_q     <= '0;
      wait_q    <= '0;
      cnt_q     <= '0;
      lock_q    <= '0;
      dirty_q   <= '0;
      pres_q    <= '0;
      for (int i = 0; i < NLINES; i++) mem_q[i] <= DW'(i);
      rsp_valid <= 1'b0;
      rsp_dst   <= '0;
      rsp_kind  <= K_SHR;
      rsp_line  <= '0;
      rsp_data  <= '0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;

      if (ack_hit) begin
        wait_q <= wait_q & ~cin_bit;
        cnt_q  <= cnt_q - 1'b1;
      end

      if (wb_evict) begin
        dirty_q[cin_line] <= 1'b0;
        pres_q[cin_line]  <= pres_q[cin_line] & ~cin_bit;
        mem_q[cin_line]   <= cin_data;
      end

      if (wb_rcl) begin
        mem_q[line_q] <= cin_data;
        st_q          <= S_RPL;
      end

      if (!idle && req_fire) begin
        rsp_valid <= 1'b1;
        rsp_dst   <= req_src;
        rsp_kind  <= K_RTY;
        rsp_line  <= req_line;
        rsp_data  <= '0;
      end

      case (st_q)
        S_IDLE: if (req_fire) begin
          src_q  <= req_src;
          line_q <= req_line;
          wr_q   <= req_wr;
          if (req_dirty && !own_self) begin
            own_q            <= low_idx(req_ent);
            lock_q[req_line] <= 1'b1;
            st_q             <= S_RCL;
          end else if (req_wr && !req_dirty && |req_oth) begin
            snd_q            <= req_oth;
            wait_q           <= req_oth;
            cnt_q            <= pop(req_oth);
            lock_q[req_line] <= 1'b1;
            st_q             <= S_INV;
          end else begin
            rsp_valid <= 1'b1;
            rsp_dst   <= req_src;
            rsp_line  <= req_line;
            rsp_data  <= mem_q[req_line];
            rsp_kind  <= (req_wr || own_self) ? K_EXC : K_SHR;
            if (!own_self) begin
              if (req_wr) begin
                pres_q[req_line]  <= req_bit;
                dirty_q[req_line] <= 1'b1;
              end else begin
                pres_q[req_line]  <= req_ent | req_bit;
              end
            end
          end
        end
        S_INV: if (prb_fire) begin
          snd_q <= snd_q & ~prb_bit;
          if ((snd_q & ~prb_bit) == '0) st_q <= S_ACK;
        end
        S_ACK: if (cnt_q == '0) st_q <= S_RPL;
        S_RCL: if (prb_fire && !wb_rcl) st_q <= S_WB;
        S_WB: ;
        S_RPL: if (!rsp_valid) begin
          rsp_valid <= 1'b1;
          rsp_dst   <= src_q;
          rsp_line  <= line_q;
          rsp_data  <= mem_q[line_q];
          rsp_kind  <= wr_q ? K_EXC : K_SHR;
          if (wr_q) begin
            pres_q[line_q]  <= src_bit;
            dirty_q[line_q] <= 1'b1;
          end else begin
            pres_q[line_q]  <= own_bit | src_bit;
            dirty_q[line_q] <= 1'b0;
          end
          lock_q[line_q] <= 1'b0;
          st_q           <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R9
  lock_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lock_q) && (idle == (lock_q == '0)));

  // R8
  retry_on_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && !idle) |=> (rsp_valid && rsp_kind == K_RTY && rsp_dst == $past(req_src)));

  // R4
  inv_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prb_valid && !prb_kind) |-> (pres_q[line_q][prb_dst] && prb_dst != src_q));

  // R4
  ack_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wait_q) == int'(cnt_q));

  // R11
  grant_after_acks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rsp_valid) && rsp_kind == K_EXC) |-> (wait_q == '0));

  // R13
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_dst) && $stable(rsp_kind)
                                   && $stable(rsp_line) && $stable(rsp_data)));

  // R13
  prb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prb_valid && !prb_ready) |=> (prb_valid && $stable(prb_dst) && $stable(prb_kind)));

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    // R7
    dirty_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dirty_q[g] |-> ($countones(pres_q[g]) == 1));
  end

endmodule

// File: tb/test_coh_dir_ctrl.sv
module test_coh_dir_ctrl;
  localparam int NC = 4, NL = 16, DW = 32, CW = 2, LW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          req_valid = 0, req_wr = 0;
  logic [CW-1:0] req_src = '0;
  logic [LW-1:0] req_line = '0;
  logic          req_ready;
  logic          rsp_valid, rsp_ready = 1;
  logic [CW-1:0] rsp_dst;
  logic [1:0]    rsp_kind;
  logic [LW-1:0] rsp_line;
  logic [DW-1:0] rsp_data;
  logic          prb_valid, prb_ready = 1, prb_kind;
  logic [CW-1:0] prb_dst;
  logic [LW-1:0] prb_line;
  logic          cin_valid = 0, cin_wb = 0;
  logic [CW-1:0] cin_src = '0;
  logic [LW-1:0] cin_line = '0;
  logic [DW-1:0] cin_data = '0;

  coh_dir_ctrl #(.NCACHE(NC), .NLINES(NL), .DW(DW)) i_coh_dir_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src),
    .req_line(req_line), .req_wr(req_wr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_dst(rsp_dst),
    .rsp_kind(rsp_kind), .rsp_line(rsp_line), .rsp_data(rsp_data),
    .prb_valid(prb_valid), .prb_ready(prb_ready), .prb_dst(prb_dst),
    .prb_kind(prb_kind), .prb_line(prb_line),
    .cin_valid(cin_valid), .cin_src(cin_src), .cin_wb(cin_wb),
    .cin_line(cin_line), .cin_data(cin_data)
  );

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;
  logic [NL-1:0] m_dirty;
  logic [NC-1:0] m_pres [NL];
  logic [DW-1:0] m_mem  [NL];

  always @(posedge clk) cycles++;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic int low_of(input logic [NC-1:0] v);
    for (int i = 0; i < NC; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic run_txn(input int src, input int line, input bit wr, input bit noise, input string tag);
    logic [NC-1:0] sbit, ent, exp_inv, exp_rec, inv_seen, rec_seen, ack_todo;
    logic [DW-1:0] wbval, exp_data;
    logic [1:0]    exp_kind;
    bit got, wb_todo, selfown;
    int noise_todo, last_dst, wb_src;
    string ktag;
    sbit = NC'(1) << src;
    ent = m_pres[line];
    selfown = m_dirty[line] && ent[src];
    exp_inv = '0; exp_rec = '0;
    wbval = $urandom;
    if (!selfown && m_dirty[line]) exp_rec = ent;
    else if (!selfown && wr) exp_inv = ent & ~sbit;
    exp_kind = (wr || selfown) ? 2'd1 : 2'd0;
    exp_data = (exp_rec != 0) ? wbval : m_mem[line];
    ktag = selfown ? "R12 owner regrant" : (wr ? "R3 exclusive grant" : "R2 shared grant");
    @(negedge clk);
    req_valid = 1; req_src = CW'(src); req_line = LW'(line); req_wr = wr;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    inv_seen = '0; rec_seen = '0; ack_todo = '0; wb_todo = 0; got = 0;
    last_dst = -1; wb_src = 0; noise_todo = noise ? 2 : 0;
    for (int cyc = 0; cyc < 100 && !got; cyc++) begin
      @(negedge clk);
      req_valid = 0; cin_valid = 0;
      if (rsp_valid) begin
        got = 1;
        chk(ack_todo == 0 && !wb_todo, {tag, " R4 R5 R11 grant before all answers"}, ack_todo, 0);
        chk(rsp_dst == CW'(src), {tag, " R2 grant destination"}, rsp_dst, src);
        chk(rsp_kind == exp_kind, {tag, " ", ktag}, rsp_kind, exp_kind);
        chk(rsp_line == LW'(line), {tag, " R2 grant block"}, rsp_line, line);
        chk(rsp_data == exp_data, {tag, " R5 R10 grant data"}, rsp_data, exp_data);
        if (exp_inv == 0 && exp_rec == 0)
          chk(cyc == 0, {tag, " R2 R3 grant latency"}, cyc, 0);
      end else if (noise_todo > 0 && ack_todo != 0) begin
        cin_valid = 1; cin_wb = 0;
        if (noise_todo == 2) begin cin_src = CW'(src); cin_line = LW'(line); end
        else begin cin_src = CW'(low_of(exp_inv)); cin_line = LW'(line ^ 1); end
        noise_todo--;
      end else if (ack_todo != 0) begin
        cin_valid = 1; cin_wb = 0;
        cin_src = CW'(low_of(ack_todo)); cin_line = LW'(line);
        ack_todo[low_of(ack_todo)] = 1'b0;
      end else if (wb_todo) begin
        cin_valid = 1; cin_wb = 1; cin_src = CW'(wb_src); cin_line = LW'(line); cin_data = wbval;
        wb_todo = 0;
      end
      if (prb_valid) begin
        chk(prb_line == LW'(line), {tag, " R4 R5 probe block"}, prb_line, line);
        if (!prb_kind) begin
          chk(!inv_seen[prb_dst] && int'(prb_dst) > last_dst, {tag, " R4 invalidate order"}, prb_dst, last_dst + 1);
          last_dst = int'(prb_dst);
          inv_seen[prb_dst] = 1'b1;
          ack_todo[prb_dst] = 1'b1;
        end else begin
          rec_seen[prb_dst] = 1'b1;
          wb_todo = 1; wb_src = int'(prb_dst);
        end
      end
    end
    @(negedge clk);
    cin_valid = 0;
    chk(got, {tag, " R2 grant arrives"}, got, 1);
    chk(inv_seen == exp_inv, {tag, " R4 R6 invalidate targets"}, inv_seen, exp_inv);
    chk(rec_seen == exp_rec, {tag, " R5 R7 recall target"}, rec_seen, exp_rec);
    if (!selfown) begin
      if (exp_rec != 0) m_mem[line] = wbval;
      if (wr) begin m_dirty[line] = 1; m_pres[line] = sbit; end
      else begin m_dirty[line] = 0; m_pres[line] = ent | sbit; end
    end
  endtask

  task automatic evict(input int src, input int line, input logic [DW-1:0] d);
    @(negedge clk);
    cin_valid = 1; cin_wb = 1; cin_src = CW'(src); cin_line = LW'(line); cin_data = d;
    @(negedge clk);
    cin_valid = 0;
    if (m_dirty[line] && m_pres[line][src]) begin
      m_dirty[line] = 0;
      m_pres[line][src] = 1'b0;
      m_mem[line] = d;
    end
  endtask

  initial begin
    wait (cycles >= 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit got;
    void'($urandom(32'd4242));
    m_dirty = '0;
    for (int i = 0; i < NL; i++) begin m_pres[i] = '0; m_mem[i] = DW'(i); end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R1 ready after reset", req_ready, 1);
    chk(rsp_valid == 0, "R1 no response after reset", rsp_valid, 0);
    chk(prb_valid == 0, "R1 no probe after reset", prb_valid, 0);

    run_txn(0, 5, 0, 0, "R1");
    run_txn(2, 5, 0, 0, "R2");
    run_txn(1, 5, 1, 0, "R4");
    run_txn(1, 5, 1, 0, "R12");
    run_txn(3, 5, 0, 0, "R6");
    run_txn(0, 5, 1, 1, "R11");
    run_txn(2, 5, 0, 0, "R7");
    run_txn(3, 6, 1, 0, "R3");

    // R13: response held while not taken
    rsp_ready = 0;
    @(negedge clk);
    req_valid = 1; req_src = 2'd0; req_line = 4'd2; req_wr = 0;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      req_valid = 0;
      chk(rsp_valid && rsp_data == m_mem[2] && rsp_dst == 2'd0, "R13 response held", rsp_data, m_mem[2]);
    end
    rsp_ready = 1;
    @(negedge clk);
    chk(!rsp_valid, "R13 response released", rsp_valid, 0);
    m_pres[2][0] = 1'b1;

    // R8 / R9: hold a recall open
    run_txn(1, 9, 1, 0, "R8");
    @(negedge clk);
    req_valid = 1; req_src = 2'd2; req_line = 4'd9; req_wr = 0;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(prb_valid && prb_kind && prb_dst == 2'd1, "R5 recall to owner", {prb_valid, prb_kind, prb_dst}, {1'b1, 1'b1, 2'd1});
    req_valid = 1; req_src = 2'd3; req_line = 4'd9; req_wr = 0;
    #1;
    chk(req_ready == 1, "R8 locked-block request taken", req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid && rsp_kind == 2'd2 && rsp_dst == 2'd3 && rsp_line == 4'd9, "R8 retry response",
        {rsp_valid, rsp_kind, rsp_dst, rsp_line}, {1'b1, 2'd2, 2'd3, 4'd9});
    @(negedge clk);
    req_valid = 1; req_src = 2'd0; req_line = 4'd10; req_wr = 1;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(req_ready == 0, "R9 other block stalled", req_ready, 0);
      @(negedge clk);
    end
    req_valid = 0;
    cin_valid = 1; cin_wb = 1; cin_src = 2'd1; cin_line = 4'd9; cin_data = 32'hABCD1234;
    @(negedge clk);
    cin_valid = 0;
    got = 0;
    for (int k = 0; k < 10 && !got; k++) begin
      if (rsp_valid) begin
        got = 1;
        chk(rsp_dst == 2'd2 && rsp_kind == 2'd0 && rsp_data == 32'hABCD1234, "R5 grant after write-back",
            rsp_data, 32'hABCD1234);
      end
      @(negedge clk);
    end
    chk(got, "R5 grant after write-back arrives", got, 1);
    m_mem[9] = 32'hABCD1234; m_dirty[9] = 0; m_pres[9] = 4'b0110;
    run_txn(0, 9, 1, 1, "R6");
    run_txn(3, 9, 0, 0, "R7");

    // R10: evictions
    run_txn(2, 11, 1, 0, "R10");
    evict(2, 11, 32'h55);
    run_txn(0, 11, 0, 0, "R10");
    evict(1, 11, 32'h99);
    run_txn(3, 11, 1, 0, "R10");

    for (int n = 0; n < 400; n++) begin
      int r, s, l;
      r = $urandom_range(0, 9);
      s = $urandom_range(0, NC - 1);
      l = $urandom_range(0, 5);
      if (r == 0) evict(s, l, $urandom);
      else run_txn(s, l, r < 5, 1'($urandom_range(0, 1)), "RND");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule